// File: doc/BRIEF.md
# Independent Watchdog Timer with Reset Status

This block guards a processor against software that stops making progress, such as a program stuck in an endless loop. It counts strobes from its own slow tick, which is separate from the processor's instruction clock. If software fails to issue a clear-watchdog strobe before the count runs out, the block raises a one-cycle reset request that sends the program counter back to its start address. Each watchdog tick is a one-cycle strobe that is synchronous to `clk`.

The time-out is a base count of `BASE_TICKS` post-divided ticks. A 1:1 to 1:128 divider stretches it when the option register's prescaler assignment bit gives that divider to the watchdog. The divider is shared with the general timer, so it only divides watchdog ticks while it is assigned here. A static configuration input enables the block, and it cannot be switched on or off at run time.

Two active-low status flags describe the last event. The time-out flag drops when the watchdog expires. The power-down flag drops when a sleep-entry strobe arrives. A clear-watchdog strobe sets both flags again.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset, `reset_req` is 0, `timeout_n` is 1 and `powerdown_n` is 1, and the internal counts start at zero.
- R2: When `presc_to_wdt` is 0, the watchdog expires on the `BASE_TICKS`-th accepted tick after a clear, whatever `rate_code` holds.
- R3: When `presc_to_wdt` is 1, `rate_code` value k (0 to 7) selects a divide ratio of 2^k. Expiry then happens on tick number `BASE_TICKS`·2^k after a clear.
- R4: On expiry, `reset_req` is high for exactly one `clk` cycle, in the cycle right after the edge that takes the expiring tick. Both counts then restart from zero, so with ticks continuing the next expiry comes one full period later.
- R5: A `clr_strobe` restarts the time-out count. A tick that arrives in the same cycle as the clear is discarded.
- R6: When the prescaler is assigned to the watchdog, `clr_strobe` also empties the prescaler count.
- R7: `clr_strobe` sets both `timeout_n` and `powerdown_n` to 1 on the next edge. It takes priority over expiry and over `sleep_entry` in the same cycle.
- R8: Expiry drives `timeout_n` to 0 in the same cycle that `reset_req` is high, and leaves `powerdown_n` unchanged.
- R9: A `sleep_entry` strobe without a clear drives `powerdown_n` to 0 and leaves `timeout_n` unchanged.
- R10: While `cfg_enable` is 0, the counts stay at zero and `reset_req` never rises, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_enable | input | 1 | Static configuration enable, fixed before operation |
| wdt_tick | input | 1 | One-cycle strobe from the watchdog's own slow time base |
| clr_strobe | input | 1 | Clear-watchdog strobe from the processor |
| sleep_entry | input | 1 | Strobe that marks entry into power-down |
| presc_to_wdt | input | 1 | Prescaler assignment: 1 gives the divider to the watchdog |
| rate_code | input | RATE_W | Divider select; code k divides by 2^k |
| reset_req | output | 1 | One-cycle reset request on expiry |
| timeout_n | output | 1 | Time-out status, 0 after an expiry |
| powerdown_n | output | 1 | Power-down status, 0 after sleep entry |

## Verification
The bench measures the time to expiry for every one of the eight rate codes with the prescaler assigned, and once with it unassigned but a large code applied. Because each code doubles the period, an off-by-one in the divider or a wrong exponent gives a different tick count. The unassigned case shows that the code is ignored.

A clear issued partway through a count, with a tick held active at the same time, tells three faults apart: a prescaler that is not emptied, a tick that is not discarded, and a base count that does not restart. Each one shifts the measured time to expiry by a different amount. Measuring a second back-to-back period shows whether the counts restart from zero after a pulse. Combining clear with sleep entry shows which strobe has priority on the status flags.

A second instance with the enable tied low receives the same stimulus and must never raise a reset request.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    // Status flags, both active low, both 1 after power-on
    typedef struct packed {
        logic timeout_n;
        logic powerdown_n;
    } wdt_status_t;

    localparam wdt_status_t STATUS_POR = '{timeout_n: 1'b1, powerdown_n: 1'b1};

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              assigned,
    input  logic [RATE_W-1:0] rate,
    input  logic              clear,
    output logic              beat
);
    localparam int PRE_W = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic             accept;
    logic             wrap;

    always_comb begin
        limit  = ~({PRE_W{1'b1}} << rate);
        accept = enable && tick && !clear;
        wrap   = !assigned || (st_q.cnt >= limit);
        beat   = accept && wrap;

        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (clear) begin
            if (assigned) st_d.cnt = '0;
        end else if (accept && assigned) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: an assigned tick that does not complete a division advances the count by one
    assert_pre_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && assigned && tick && !clear && !beat) |=> st_q.cnt == PRE_W'($past(st_q.cnt) + 1'b1));

    // R6: a clear while assigned leaves the prescaler empty
    assert_pre_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && assigned && clear) |=> st_q.cnt == '0);

endmodule

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
    parameter int BASE_TICKS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic beat,
    input  logic clear,
    output logic expire,
    output logic reset_req
);
    localparam int CNT_W = $clog2(BASE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        expire = enable && beat && !clear && (st_q.cnt == LAST);

        st_d     = st_q;
        st_d.req = expire;
        if (!enable || clear) begin
            st_d.cnt = '0;
        end else if (beat) begin
            st_d.cnt = expire ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reset_req = st_q.req;

    // R4: the reset request never lasts two cycles
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R5: a clear restarts the base count
    assert_clear_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0 && !reset_req));

    // R10: a disabled watchdog keeps its count at zero and stays quiet
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0 && !reset_req));

endmodule

// File: rtl/wdt_status.sv
module wdt_status
    import wdt_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        expire,
    input  logic        sleep_entry,
    output wdt_status_t status
);
    wdt_status_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = STATUS_POR;
        end else begin
            if (expire)      st_d.timeout_n   = 1'b0;
            if (sleep_entry) st_d.powerdown_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATUS_POR;
        else        st_q <= st_d;
    end

    assign status = st_q;

    // R7: a clear leaves both flags set on the next cycle
    assert_clear_sets_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (status.timeout_n && status.powerdown_n));

    // R9: sleep entry alone does not disturb the time-out flag
    assert_sleep_keeps_to_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_entry && !clear && !expire) |=> status.timeout_n == $past(status.timeout_n));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_TICKS = 18,
    parameter int RATE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              wdt_tick,
    input  logic              clr_strobe,
    input  logic              sleep_entry,
    input  logic              presc_to_wdt,
    input  logic [RATE_W-1:0] rate_code,
    output logic              reset_req,
    output logic              timeout_n,
    output logic              powerdown_n
);
    logic        beat;
    logic        expire;
    wdt_status_t status;

    wdt_prescale #(.RATE_W(RATE_W)) prescale_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_enable),
        .tick     (wdt_tick),
        .assigned (presc_to_wdt),
        .rate     (rate_code),
        .clear    (clr_strobe),
        .beat     (beat)
    );

    wdt_base_counter #(.BASE_TICKS(BASE_TICKS)) base_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .beat      (beat),
        .clear     (clr_strobe),
        .expire    (expire),
        .reset_req (reset_req)
    );

    wdt_status status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clr_strobe),
        .expire      (expire),
        .sleep_entry (sleep_entry),
        .status      (status)
    );

    assign timeout_n   = status.timeout_n;
    assign powerdown_n = status.powerdown_n;

    // R8: the reset pulse and the cleared time-out flag appear together
    assert_pulse_marks_to_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !timeout_n);

    // R8: expiry leaves the power-down flag as it was
    assert_pulse_keeps_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !$past(sleep_entry)) |-> $stable(powerdown_n));

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
    localparam int BASE   = 18;
    localparam int RATE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdt_tick = 1'b0;
    logic clr_strobe = 1'b0;
    logic sleep_entry = 1'b0;
    logic presc_to_wdt = 1'b0;
    logic [RATE_W-1:0] rate_code = '0;
    logic reset_req, timeout_n, powerdown_n;
    logic off_req, off_to_n, off_pd_n;

    int checks = 0;
    int errors = 0;
    int off_pulses = 0;

    always #5 clk = ~clk;

    wdt_guard #(.BASE_TICKS(BASE), .RATE_W(RATE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(1'b1), .wdt_tick(wdt_tick),
        .clr_strobe(clr_strobe), .sleep_entry(sleep_entry), .presc_to_wdt(presc_to_wdt),
        .rate_code(rate_code), .reset_req(reset_req), .timeout_n(timeout_n),
        .powerdown_n(powerdown_n)
    );

    wdt_guard #(.BASE_TICKS(BASE), .RATE_W(RATE_W)) dut_off_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(1'b0), .wdt_tick(wdt_tick),
        .clr_strobe(clr_strobe), .sleep_entry(sleep_entry), .presc_to_wdt(presc_to_wdt),
        .rate_code(rate_code), .reset_req(off_req), .timeout_n(off_to_n),
        .powerdown_n(off_pd_n)
    );

    always @(negedge clk) if (rst_n && off_req) off_pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endfunction

    // Count edges with tick held high until a reset pulse is seen
    task automatic count_to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!reset_req && n < 5000);
    endtask

    task automatic pulse_clear();
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
    endtask

    // Measure two back-to-back periods from a clear
    task automatic measure(input int expn, input string req);
        int n;
        wdt_tick = 1'b0;
        pulse_clear();
        check(timeout_n && powerdown_n, "R7 clear sets flags", {timeout_n, powerdown_n}, 3);
        wdt_tick = 1'b1;
        count_to_pulse(n);
        check(n == expn, req, n, expn);
        check(!timeout_n, "R8 expiry clears timeout_n", timeout_n, 0);
        check(powerdown_n, "R8 expiry keeps powerdown_n", powerdown_n, 1);
        count_to_pulse(n);
        check(n == expn, "R4 restart from zero after pulse", n, expn);
        @(negedge clk);
        check(!reset_req, "R4 one-cycle pulse", reset_req, 0);
        wdt_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!reset_req, "R1 reset_req after reset", reset_req, 0);
        check(timeout_n, "R1 timeout_n after reset", timeout_n, 1);
        check(powerdown_n, "R1 powerdown_n after reset", powerdown_n, 1);

        // R2: unassigned, large code must be ignored
        presc_to_wdt = 1'b0;
        rate_code = 3'd7;
        measure(BASE, "R2 unassigned period");

        // R3: sweep all rate codes
        presc_to_wdt = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rate_code = RATE_W'(k);
            measure(BASE * (1 << k), "R3 assigned period");
        end

        // R5 and R6: mid-count clear with a tick in the same cycle
        rate_code = 3'd3;
        pulse_clear();
        wdt_tick = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            check(!reset_req, "R5 no early pulse", reset_req, 0);
        end
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        count_to_pulse(n);
        check(n == BASE * 8, "R5/R6 clear restarts count and prescaler", n, BASE * 8);
        wdt_tick = 1'b0;
        @(negedge clk);

        // R9: sleep entry alone, timeout_n is 0 here from the last expiry
        sleep_entry = 1'b1;
        @(negedge clk);
        sleep_entry = 1'b0;
        check(!powerdown_n, "R9 sleep clears powerdown_n", powerdown_n, 0);
        check(!timeout_n, "R9 sleep keeps timeout_n", timeout_n, 0);
        // R7: clear wins over sleep in the same cycle
        sleep_entry = 1'b1;
        clr_strobe = 1'b1;
        @(negedge clk);
        sleep_entry = 1'b0;
        clr_strobe = 1'b0;
        check(powerdown_n && timeout_n, "R7 clear priority over sleep", {timeout_n, powerdown_n}, 3);
        sleep_entry = 1'b1;
        @(negedge clk);
        sleep_entry = 1'b0;
        check(!powerdown_n && timeout_n, "R9 sleep with timeout_n set", {timeout_n, powerdown_n}, 2);

        // R10: disabled instance saw every tick and never pulsed
        check(off_pulses == 0, "R10 disabled never resets", off_pulses, 0);
        check(off_to_n, "R10 disabled keeps timeout_n", off_to_n, 1);

        summary();
        $finish;
    end

endmodule